// File: doc/BRIEF.md
# Dual Limited-Range Segment Counter

This block chooses which quarter of a 64-bit internal word a 16-bit data bus reaches on each data cycle. It keeps two counters that do not affect each other. One steers data reads and the other steers data writes. Each counter holds three 2-bit fields: a first segment, a last segment and the segment now in use. After each data cycle of its own kind, the counter moves on by one segment. When it reaches its last segment, it returns to its first.

A now-value loaded outside the first-to-last window keeps counting upward. It wraps from 3 to 0 and goes on until it meets the last segment, then joins the limited cycle. A first segment above the last segment follows the same rule, so every loaded value gives a defined sequence.

The fields sit in one 16-bit control word. The block holds two full copies of that word, a primary set and an alternate set. A select input picks which set is written, read back and advanced. A restart command puts both now-values of the selected set back to their first segments, so an interrupted burst can start again.

Top module: `seg_counter_dual`

## Requirements
- R1: After reset both sets hold first=0, last=3, now=0 for both counters: rd_seg=0, wr_seg=0, cfg_rdata=16'h1818.
- R2: A rd_cycle advances only the read now-value of the selected set by one. A wr_cycle advances only the write now-value. Both may occur in the same clock. With no strobe, the now-values hold.
- R3: A now-value equal to its last segment is replaced by the first segment on the next advance.
- R4: A now-value above its last segment counts up to 3, wraps to 0 and goes on to the last segment. This includes the case where first is above last.
- R5: restart loads both now-values of the selected set from their first segments.
- R6: cfg_we loads the selected set from cfg_wdata with this layout: [14:13] read first, [12:11] read last, [9:8] read now, [7:6] write first, [4:3] write last, [1:0] write now. A write beats any restart or data strobe in the same clock.
- R7: cfg_rdata bits 15, 10, 5 and 2 always read 0, whatever was written to them.
- R8: set_sel (0 = primary, 1 = alternate) picks the set that is written, read back, restarted and advanced. The other set holds its state.
- R9: restart beats rd_cycle and wr_cycle in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load selected set from cfg_wdata |
| cfg_wdata | input | 16 | Control word to load |
| rd_cycle | input | 1 | A data read cycle completed |
| wr_cycle | input | 1 | A data write cycle completed |
| restart | input | 1 | Reload now-values from first segments |
| set_sel | input | 1 | Register set select |
| rd_seg | output | 2 | Segment for the next data read |
| wr_seg | output | 2 | Segment for the next data write |
| cfg_rdata | output | 16 | Control word of the selected set |

## Verification
A wrong now-value shows on rd_seg or wr_seg in the cycle right after the faulty step. A wrong wrap or roll-through decision shows at the first advance that meets the last segment or goes past 3. A limit field that is corrupt or decoded in the wrong place shows at once in cfg_rdata. It later shows as a wrong wrap target. Leakage between the two sets shows as soon as set_sel returns to the untouched set.

// File: rtl/segctr_pkg.sv
package segctr_pkg;

   localparam int SEG_W = 2;
   localparam int REG_W = 16;

   typedef logic [SEG_W-1:0] seg_t;

   typedef struct packed {
      seg_t first;
      seg_t last;
      seg_t now;
   } lane_t;

   localparam int LANES   = 2;
   localparam int LANE_RD = 0;
   localparam int LANE_WR = 1;

   // field least-significant bit positions, per lane
   localparam int RD_FIRST_LSB = 13;
   localparam int RD_LAST_LSB  = 11;
   localparam int RD_NOW_LSB   = 8;
   localparam int WR_FIRST_LSB = 6;
   localparam int WR_LAST_LSB  = 3;
   localparam int WR_NOW_LSB   = 0;

   localparam logic [REG_W-1:0] RSVD_MASK = 16'h8424;

   localparam seg_t  SEG_TOP    = '1;
   localparam lane_t LANE_RESET = '{first: '0, last: SEG_TOP, now: '0};

   function automatic int first_lsb(input int lane);
      return (lane == LANE_RD) ? RD_FIRST_LSB : WR_FIRST_LSB;
   endfunction

   function automatic int last_lsb(input int lane);
      return (lane == LANE_RD) ? RD_LAST_LSB : WR_LAST_LSB;
   endfunction

   function automatic int now_lsb(input int lane);
      return (lane == LANE_RD) ? RD_NOW_LSB : WR_NOW_LSB;
   endfunction

   function automatic lane_t word_to_lane(input logic [REG_W-1:0] w, input int lane);
      lane_t l;
      l.first = w[first_lsb(lane) +: SEG_W];
      l.last  = w[last_lsb(lane)  +: SEG_W];
      l.now   = w[now_lsb(lane)   +: SEG_W];
      return l;
   endfunction

   function automatic logic [REG_W-1:0] lanes_to_word(input lane_t rd, input lane_t wr);
      logic [REG_W-1:0] w;
      w = '0;
      w[RD_FIRST_LSB +: SEG_W] = rd.first;
      w[RD_LAST_LSB  +: SEG_W] = rd.last;
      w[RD_NOW_LSB   +: SEG_W] = rd.now;
      w[WR_FIRST_LSB +: SEG_W] = wr.first;
      w[WR_LAST_LSB  +: SEG_W] = wr.last;
      w[WR_NOW_LSB   +: SEG_W] = wr.now;
      return w;
   endfunction

endpackage

// File: rtl/segctr_step.sv
// Next segment for one advance: last -> first, otherwise +1 modulo the
// segment count, which yields the roll-through for out-of-window values.
module segctr_step
   import segctr_pkg::*;
#(
   parameter int W = SEG_W
) (
   input  logic [W-1:0] now,
   input  logic [W-1:0] first,
   input  logic [W-1:0] last,
   output logic [W-1:0] next
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic          at_last;
   logic [W-1:0]  incr;

   assign at_last = (now == last);
   assign incr    = now + ONE;   // natural wrap of the top segment to 0
   assign next    = at_last ? first : incr;
endmodule

// File: rtl/segctr_lane.sv
// One counter: first/last/now with load > restart > advance priority.
module segctr_lane
   import segctr_pkg::*;
#(
   parameter lane_t RESET_VAL = LANE_RESET
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  active,
   input  logic  load,
   input  lane_t load_val,
   input  logic  restart,
   input  logic  advance,
   output lane_t state
);
   lane_t lane_q, lane_d;
   seg_t  stepped;

   segctr_step #(.W(SEG_W)) u_step (
      .now   (lane_q.now),
      .first (lane_q.first),
      .last  (lane_q.last),
      .next  (stepped)
   );

   always_comb begin
      lane_d = lane_q;
      if (active) begin
         if (load)
            lane_d = load_val;
         else if (restart)
            lane_d.now = lane_q.first;
         else if (advance)
            lane_d.now = stepped;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= RESET_VAL;
      else        lane_q <= lane_d;
   end

   assign state = lane_q;
endmodule

// File: rtl/segctr_set.sv
// One register set: a read lane and a write lane decoded from one word.
module segctr_set
   import segctr_pkg::*;
#(
   parameter int WORD_W = REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              cfg_we,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              restart,
   input  logic              rd_cycle,
   input  logic              wr_cycle,
   output lane_t             rd_lane,
   output lane_t             wr_lane
);
   lane_t lane_st [LANES];
   logic  lane_adv [LANES];

   assign lane_adv[LANE_RD] = rd_cycle;
   assign lane_adv[LANE_WR] = wr_cycle;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      segctr_lane #(.RESET_VAL(LANE_RESET)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (active),
         .load     (cfg_we),
         .load_val (word_to_lane(cfg_wdata, g)),
         .restart  (restart),
         .advance  (lane_adv[g]),
         .state    (lane_st[g])
      );
   end

   assign rd_lane = lane_st[LANE_RD];
   assign wr_lane = lane_st[LANE_WR];
endmodule

// File: rtl/seg_counter_dual.sv
module seg_counter_dual
   import segctr_pkg::*;
#(
   parameter  int NUM_SETS = 2,
   parameter  int WORD_W   = REG_W,
   parameter  int SEGW     = SEG_W,
   localparam int SEL_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              rd_cycle,
   input  logic              wr_cycle,
   input  logic              restart,
   input  logic [SEL_W-1:0]  set_sel,
   output logic [SEGW-1:0]   rd_seg,
   output logic [SEGW-1:0]   wr_seg,
   output logic [WORD_W-1:0] cfg_rdata
);
   if (WORD_W != REG_W) begin : g_bad_word
      $error("seg_counter_dual: WORD_W must equal the packed layout width");
   end
   if (SEGW != SEG_W) begin : g_bad_seg
      $error("seg_counter_dual: SEGW must equal the package segment width");
   end
   if (NUM_SETS < 2 || (1 << SEL_W) != NUM_SETS) begin : g_bad_sets
      $error("seg_counter_dual: NUM_SETS must be a power of two, at least 2");
   end

   lane_t rd_lanes [NUM_SETS];
   lane_t wr_lanes [NUM_SETS];
   lane_t rd_cur, wr_cur;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      segctr_set #(.WORD_W(WORD_W)) u_set (
         .clk       (clk),
         .rst_n     (rst_n),
         .active    (set_sel == SEL_W'(s)),
         .cfg_we    (cfg_we),
         .cfg_wdata (cfg_wdata),
         .restart   (restart),
         .rd_cycle  (rd_cycle),
         .wr_cycle  (wr_cycle),
         .rd_lane   (rd_lanes[s]),
         .wr_lane   (wr_lanes[s])
      );
   end

   assign rd_cur    = rd_lanes[set_sel];
   assign wr_cur    = wr_lanes[set_sel];
   assign rd_seg    = rd_cur.now;
   assign wr_seg    = wr_cur.now;
   assign cfg_rdata = lanes_to_word(rd_cur, wr_cur);
endmodule

// File: rtl/seg_counter_dual_chk.sv
module seg_counter_dual_chk
   import segctr_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic [15:0] cfg_wdata,
   input logic        rd_cycle,
   input logic        wr_cycle,
   input logic        restart,
   input logic [0:0]  set_sel,
   input logic [1:0]  rd_seg,
   input logic [1:0]  wr_seg,
   input logic [15:0] cfg_rdata
);
   logic [1:0] rd_first, rd_last, wr_first, wr_last;
   assign rd_first = cfg_rdata[14:13];
   assign rd_last  = cfg_rdata[12:11];
   assign wr_first = cfg_rdata[7:6];
   assign wr_last  = cfg_rdata[4:3];

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (cfg_rdata == 16'h1818 && rd_seg == 2'd0 && wr_seg == 2'd0));

   assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cycle && !cfg_we && !restart ##1 set_sel == $past(set_sel) |->
      rd_seg == (($past(rd_seg) == $past(rd_last)) ? $past(rd_first) : 2'($past(rd_seg) + 2'd1)));

   assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cycle && !cfg_we && !restart ##1 set_sel == $past(set_sel) |->
      wr_seg == (($past(wr_seg) == $past(wr_last)) ? $past(wr_first) : 2'($past(wr_seg) + 2'd1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cycle && !wr_cycle && !cfg_we && !restart ##1 set_sel == $past(set_sel) |->
      $stable(cfg_rdata));

   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart && !cfg_we ##1 set_sel == $past(set_sel) |->
      (rd_seg == $past(rd_first) && wr_seg == $past(wr_first)));

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we ##1 set_sel == $past(set_sel) |->
      cfg_rdata == ($past(cfg_wdata) & ~RSVD_MASK));

   assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & RSVD_MASK) == 16'h0);
endmodule

bind seg_counter_dual seg_counter_dual_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .rd_cycle  (rd_cycle),
   .wr_cycle  (wr_cycle),
   .restart   (restart),
   .set_sel   (set_sel),
   .rd_seg    (rd_seg),
   .wr_seg    (wr_seg),
   .cfg_rdata (cfg_rdata)
);

// File: tb/tb_seg_counter_dual.sv
`timescale 1ns/1ps
module tb_seg_counter_dual;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        rd_cycle = 1'b0;
   logic        wr_cycle = 1'b0;
   logic        restart = 1'b0;
   logic [0:0]  set_sel = 1'b0;
   logic [1:0]  rd_seg, wr_seg;
   logic [15:0] cfg_rdata;

   int applied = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   seg_counter_dual dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .restart(restart),
      .set_sel(set_sel), .rd_seg(rd_seg), .wr_seg(wr_seg), .cfg_rdata(cfg_rdata)
   );

   // expected control word: [14:13] rd first, [12:11] rd last, [9:8] rd now,
   // [7:6] wr first, [4:3] wr last, [1:0] wr now, reserved bits zero
   function automatic logic [15:0] pk(input logic [1:0] rf, rl, rn, wf, wl, wn);
      return {1'b0, rf, rl, 1'b0, rn, wf, 1'b0, wl, 1'b0, wn};
   endfunction

   // {we, wdata[16], rd, wr, restart, sel, exp_rd[2], exp_wr[2], exp_word[16]}
   function automatic logic [40:0] v(input logic we, input logic [15:0] wd,
                                     input logic rd, wr, rs, sel,
                                     input logic [1:0] erd, ewr,
                                     input logic [15:0] ew);
      return {we, wd, rd, wr, rs, sel, erd, ewr, ew};
   endfunction

   localparam int NV = 25;
   localparam logic [40:0] VEC [NV] = '{
      v(0, 16'h0, 1, 0, 0, 0, 2'd1, 2'd0, pk(0,3,1,0,3,0)),                // R2
      v(0, 16'h0, 1, 1, 0, 0, 2'd2, 2'd1, pk(0,3,2,0,3,1)),                // R2
      v(0, 16'h0, 1, 0, 0, 0, 2'd3, 2'd1, pk(0,3,3,0,3,1)),                // R2
      v(0, 16'h0, 1, 0, 0, 0, 2'd0, 2'd1, pk(0,3,0,0,3,1)),                // R3
      v(1, pk(1,2,3,2,3,0) | 16'h8424, 0, 0, 0, 0, 2'd3, 2'd0, pk(1,2,3,2,3,0)), // R6 R7
      v(0, 16'h0, 1, 1, 0, 0, 2'd0, 2'd1, pk(1,2,0,2,3,1)),                // R4
      v(0, 16'h0, 1, 1, 0, 0, 2'd1, 2'd2, pk(1,2,1,2,3,2)),                // R4
      v(0, 16'h0, 1, 1, 0, 0, 2'd2, 2'd3, pk(1,2,2,2,3,3)),                // R2
      v(0, 16'h0, 1, 1, 0, 0, 2'd1, 2'd2, pk(1,2,1,2,3,2)),                // R3
      v(0, 16'h0, 1, 1, 0, 0, 2'd2, 2'd3, pk(1,2,2,2,3,3)),                // R2
      v(0, 16'h0, 0, 0, 1, 0, 2'd1, 2'd2, pk(1,2,1,2,3,2)),                // R5
      v(0, 16'h0, 1, 1, 1, 0, 2'd1, 2'd2, pk(1,2,1,2,3,2)),                // R9
      v(1, pk(3,1,2,0,0,0), 1, 1, 1, 0, 2'd2, 2'd0, pk(3,1,2,0,0,0)),      // R6 priority
      v(0, 16'h0, 1, 1, 0, 0, 2'd3, 2'd0, pk(3,1,3,0,0,0)),                // R4 first>last
      v(0, 16'h0, 1, 0, 0, 0, 2'd0, 2'd0, pk(3,1,0,0,0,0)),                // R4
      v(0, 16'h0, 1, 0, 0, 0, 2'd1, 2'd0, pk(3,1,1,0,0,0)),                // R4
      v(0, 16'h0, 1, 0, 0, 0, 2'd3, 2'd0, pk(3,1,3,0,0,0)),                // R3
      v(0, 16'h0, 1, 0, 0, 0, 2'd0, 2'd0, pk(3,1,0,0,0,0)),                // R4
      v(0, 16'h0, 1, 0, 0, 1, 2'd1, 2'd0, pk(0,3,1,0,3,0)),                // R8
      v(0, 16'h0, 0, 0, 0, 0, 2'd0, 2'd0, pk(3,1,0,0,0,0)),                // R8
      v(1, pk(2,2,0,1,1,1), 0, 0, 0, 1, 2'd0, 2'd1, pk(2,2,0,1,1,1)),      // R8 R6
      v(0, 16'h0, 0, 0, 0, 0, 2'd0, 2'd0, pk(3,1,0,0,0,0)),                // R8
      v(0, 16'h0, 1, 1, 0, 1, 2'd1, 2'd1, pk(2,2,1,1,1,1)),                // R8 R3
      v(0, 16'h0, 0, 0, 1, 1, 2'd2, 2'd1, pk(2,2,2,1,1,1)),                // R5 R8
      v(0, 16'h0, 0, 0, 0, 0, 2'd0, 2'd0, pk(3,1,0,0,0,0))                 // R8
   };

   task automatic check(input string req, input logic [1:0] erd, ewr,
                        input logic [15:0] ew);
      applied++;
      if (rd_seg !== erd || wr_seg !== ewr || cfg_rdata !== ew) begin
         miscompares++;
         $display("FAIL %s: rd_seg=%0d wr_seg=%0d word=%h, expected %0d %0d %h",
                  req, rd_seg, wr_seg, cfg_rdata, erd, ewr, ew);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 2'd0, 2'd0, 16'h1818);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 2'd0, 2'd0, 16'h1818);

      for (int i = 0; i < NV; i++) begin
         {cfg_we, cfg_wdata, rd_cycle, wr_cycle, restart, set_sel} = VEC[i][40:20];
         @(negedge clk);
         check($sformatf("vector %0d (R2..R9)", i), VEC[i][19:18], VEC[i][17:16], VEC[i][15:0]);
      end
      {cfg_we, rd_cycle, wr_cycle, restart} = '0;

      // R2: idle cycles hold
      repeat (2) @(negedge clk);
      check("R2 hold idle", 2'd0, 2'd0, pk(3,1,0,0,0,0));

      // R1: mid-run reset returns both sets to defaults
      rst_n = 1'b0;
      @(negedge clk);
      set_sel = 1'b0;
      #1 check("R1 primary reset", 2'd0, 2'd0, 16'h1818);
      set_sel = 1'b1;
      #1 check("R1 alternate reset", 2'd0, 2'd0, 16'h1818);
      set_sel = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R4: loaded now=2 above last=1 with first=0: 2,3,0,1,0
      cfg_we = 1'b1; cfg_wdata = pk(0,1,2,0,1,2);
      @(negedge clk);
      cfg_we = 1'b0; rd_cycle = 1'b1;
      @(negedge clk); check("R4 roll 2->3", 2'd3, 2'd2, pk(0,1,3,0,1,2));
      @(negedge clk); check("R4 roll 3->0", 2'd0, 2'd2, pk(0,1,0,0,1,2));
      @(negedge clk); check("R4 roll 0->1", 2'd1, 2'd2, pk(0,1,1,0,1,2));
      @(negedge clk); check("R3 wrap 1->0", 2'd0, 2'd2, pk(0,1,0,0,1,2));
      rd_cycle = 1'b0;
      @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end
endmodule